// File: doc/BRIEF.md
# Engine busy and interrupt controller

This block is the control and status logic placed next to a drawing engine's command sequencer. A plain register write port reaches two registers: a halt register that asks the engine's state machines to stop and go idle, and a configuration register that holds an interrupt-enable bit and a busy-mode select, plus a self-clearing interrupt-clear bit. From the engine it takes three plain level inputs: state machine active, memory writes still outstanding, and command FIFO empty.

From these inputs it keeps a registered busy flag in one of two modes. In the completion mode, busy rises when the state machine starts and falls only once the engine is fully drained. In the queue mode, busy simply follows "active or FIFO holding commands". Every genuine fall of busy sets an interrupt flop. That flop is masked only at the output pin. A combinational read port returns the configuration and halt state.

Top module: `de_status_ctrl`

## Requirements
- R1: On a synchronous active-low reset, busy, the interrupt flop, the interrupt output, the halt request, the mode bit and the enable bit all become 0.
- R2: A write to the halt register (offset 0x04) sets the halt request from the next clock edge if data bits 7:0 are nonzero, and clears it if they are zero. Writes to other offsets leave it unchanged.
- R3: Setting or clearing the halt request leaves the configuration register unchanged.
- R4: In mode 0 (configuration bit 9 = 0), busy is 1 one cycle after state machine active is seen. It then stays 1 while memory writes are pending or the FIFO is not empty. It falls in the cycle after all three show idle.
- R5: In mode 1 (bit 9 = 1), busy in each cycle equals (state machine active OR FIFO not empty) as sampled at the preceding edge.
- R6: The interrupt flop is set at the same edge at which busy goes from 1 to 0.
- R7: A configuration write with bit 10 = 1 clears the interrupt flop at that edge. If a busy fall happens at the same edge, the set wins.
- R8: The interrupt output equals the flop AND the enable bit (bit 8). The flop keeps capturing events and holds its value while enable is 0.
- R9: While the halt request is 1, busy is 0 from the next edge. A fall of busy caused by the halt does not set the interrupt flop.
- R10: A read of the configuration offset (0x08) returns the mode in bit 9 and the enable in bit 8, with 0 in bit 10 and in all other bits. A read of the halt offset returns the halt request in bit 0 and 0 elsewhere. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Combinational read data |
| sm_active | input | 1 | Engine state machine active |
| mem_wr_pend | input | 1 | Engine memory writes outstanding |
| cmd_fifo_empty | input | 1 | Engine command FIFO empty |
| busy | output | 1 | Registered busy status |
| irq | output | 1 | Masked interrupt output |
| halt_req | output | 1 | Halt/idle request to the engine |

## Verification
A write takes effect at the edge that samples it, so halt, mode, enable and the clear action are visible one cycle after the strobe. Busy is one register behind the engine inputs, and a forced halt reaches busy one further edge after the halt register changes. The interrupt flop changes at the same edge as the busy fall that sets it. Read data is combinational on the current state. The bench drives every input just after the falling edge and compares all outputs with its model at the next falling edge, so each result is sampled exactly one rising edge after its cause.

// File: rtl/de_ctl_pkg.sv
package de_ctl_pkg;
  localparam int CLR_BIT  = 10;
  localparam int MODE_BIT = 9;
  localparam int EN_BIT   = 8;
  localparam int HALT_W   = 8;

  typedef struct packed {
    logic mode;
    logic irq_en;
  } cfg_t;
endpackage

// File: rtl/de_ctl_regs.sv
module de_ctl_regs
  import de_ctl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int SRST_ADDR = 4,
  parameter int CFG_ADDR  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output cfg_t              cfg_o,
  output logic              halt_o,
  output logic              clr_o
);
  localparam logic [ADDR_W-1:0] SRST_A = ADDR_W'(SRST_ADDR);
  localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_ADDR);

  logic wr_srst, wr_cfg;
  cfg_t cfg_q;
  logic halt_q;

  assign wr_srst = wr_en && (wr_addr == SRST_A);
  assign wr_cfg  = wr_en && (wr_addr == CFG_A);
  assign clr_o   = wr_cfg && wr_data[CLR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      halt_q <= 1'b0;
    end else begin
      if (wr_cfg) begin
        cfg_q.mode   <= wr_data[MODE_BIT];
        cfg_q.irq_en <= wr_data[EN_BIT];
      end
      if (wr_srst) halt_q <= |wr_data[HALT_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == CFG_A) begin
      rd_data[MODE_BIT] = cfg_q.mode;
      rd_data[EN_BIT]   = cfg_q.irq_en;
    end else if (rd_addr == SRST_A) begin
      rd_data[0] = halt_q;
    end
  end

  assign cfg_o  = cfg_q;
  assign halt_o = halt_q;

  // R2
  halt_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_srst |=> halt_q == $past(|wr_data[HALT_W-1:0]));
  // R3
  cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cfg |=> $stable(cfg_q));
  // R10
  rd_clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[CLR_BIT] == 1'b0);
endmodule

// File: rtl/de_busy_gen.sv
module de_busy_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic halt_i,
  input  logic sm_active_i,
  input  logic mem_pend_i,
  input  logic fifo_empty_i,
  output logic busy_o,
  output logic fall_o
);
  logic busy_q, busy_d, drained;

  assign drained = !sm_active_i && !mem_pend_i && fifo_empty_i;

  always_comb begin
    if (halt_i)      busy_d = 1'b0;
    else if (mode_i) busy_d = sm_active_i || !fifo_empty_i;
    else             busy_d = sm_active_i || (busy_q && !drained);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign busy_o = busy_q;
  assign fall_o = busy_q && !busy_d && !halt_i;

  // R9
  halt_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> !busy_o);
  // R4
  mode0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && !halt_i && busy_o && mem_pend_i) |=> busy_o);
  // R5
  mode1_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && !halt_i) |=> busy_o == $past(sm_active_i || !fifo_empty_i));
endmodule

// File: rtl/de_irq_unit.sv
module de_irq_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign irq_o = flag_q && en_i;

  // R6
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
  // R7
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);
  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(flag_q));
endmodule

// File: rtl/de_status_ctrl.sv
module de_status_ctrl
  import de_ctl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int SRST_ADDR = 4,
  parameter int CFG_ADDR  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sm_active,
  input  logic              mem_wr_pend,
  input  logic              cmd_fifo_empty,
  output logic              busy,
  output logic              irq,
  output logic              halt_req
);
  cfg_t cfg;
  logic halt, clr, fall;

  de_ctl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SRST_ADDR(SRST_ADDR), .CFG_ADDR(CFG_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .cfg_o(cfg), .halt_o(halt), .clr_o(clr)
  );

  de_busy_gen u_busy (
    .clk(clk), .rst_n(rst_n),
    .mode_i(cfg.mode), .halt_i(halt),
    .sm_active_i(sm_active), .mem_pend_i(mem_wr_pend),
    .fifo_empty_i(cmd_fifo_empty),
    .busy_o(busy), .fall_o(fall)
  );

  de_irq_unit u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_i(fall), .clr_i(clr), .en_i(cfg.irq_en),
    .irq_o(irq)
  );

  assign halt_req = halt;

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.irq_en |-> !irq);
  // R1
  rst_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!busy && !irq && !halt_req));
endmodule

// File: tb/sim_de_status_ctrl.sv
module sim_de_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = 8'h08;
  logic [31:0] rd_data;
  logic        sm_active = 1'b0, mem_wr_pend = 1'b0, cmd_fifo_empty = 1'b1;
  logic        busy, irq, halt_req;

  int n_chk = 0, n_fail = 0;
  bit started = 0, done = 0;

  always #2 clk = ~clk;

  de_status_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sm_active(sm_active), .mem_wr_pend(mem_wr_pend),
    .cmd_fifo_empty(cmd_fifo_empty), .busy(busy), .irq(irq),
    .halt_req(halt_req)
  );

  // behavioural reference state
  bit m_busy, m_flag, m_halt, m_mode, m_en;
  bit nb, ev;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_flag <= 0; m_halt <= 0; m_mode <= 0; m_en <= 0;
    end else begin
      if (m_halt) nb = 0;
      else if (m_mode) nb = sm_active | !cmd_fifo_empty;
      else if (sm_active) nb = 1;
      else if (m_busy && (mem_wr_pend || !cmd_fifo_empty)) nb = 1;
      else nb = 0;
      ev = m_busy && !nb && !m_halt;
      if (ev) m_flag <= 1;
      else if (wr_en && wr_addr == 8'h08 && wr_data[10]) m_flag <= 0;
      if (wr_en && wr_addr == 8'h08) begin
        m_mode <= wr_data[9];
        m_en   <= wr_data[8];
      end
      if (wr_en && wr_addr == 8'h04) m_halt <= (wr_data[7:0] != 0);
      m_busy <= nb;
    end
  end

  function automatic logic [31:0] exp_rd();
    if (rd_addr == 8'h08) return {22'd0, m_mode, m_en, 8'd0};
    if (rd_addr == 8'h04) return {31'd0, m_halt};
    return 32'd0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) if (started) begin
    chk("R4 R5 R9 busy", {31'd0, busy}, {31'd0, m_busy});
    chk("R6 R7 R8 irq", {31'd0, irq}, {31'd0, m_flag & m_en});
    chk("R2 halt_req", {31'd0, halt_req}, {31'd0, m_halt});
    chk("R3 R10 rd_data", rd_data, exp_rd());
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; started = 1;
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 halt", {31'd0, halt_req}, 0);
    chk("R1 cfg", rd_data, 0);

    wr(8'h08, 32'h100);
    sm_active = 1; tick();
    chk("R4 busy rise", {31'd0, busy}, 1);
    sm_active = 0; mem_wr_pend = 1; tick();
    chk("R4 pending hold", {31'd0, busy}, 1);
    mem_wr_pend = 0; cmd_fifo_empty = 0; tick();
    chk("R4 fifo hold", {31'd0, busy}, 1);
    cmd_fifo_empty = 1; tick();
    chk("R4 busy fall", {31'd0, busy}, 0);
    chk("R6 irq set", {31'd0, irq}, 1);
    wr(8'h08, 32'h500);
    chk("R7 clear", {31'd0, irq}, 0);
    chk("R10 clr reads 0", rd_data, 32'h100);

    sm_active = 1; tick();
    sm_active = 0;
    wr(8'h08, 32'h500);
    chk("R7 set wins", {31'd0, irq}, 1);
    wr(8'h08, 32'h000);
    chk("R8 masked", {31'd0, irq}, 0);
    wr(8'h08, 32'h100);
    chk("R8 flop kept", {31'd0, irq}, 1);
    wr(8'h08, 32'h500);

    wr(8'h08, 32'h300);
    cmd_fifo_empty = 0; tick();
    chk("R5 busy on fifo", {31'd0, busy}, 1);
    cmd_fifo_empty = 1; tick();
    chk("R5 busy off", {31'd0, busy}, 0);
    chk("R6 irq mode1", {31'd0, irq}, 1);
    wr(8'h08, 32'h700);

    sm_active = 1; tick();
    wr(8'h04, 32'h1);
    chk("R2 halt set", {31'd0, halt_req}, 1);
    tick();
    chk("R9 forced idle", {31'd0, busy}, 0);
    chk("R9 no event", {31'd0, irq}, 0);
    chk("R3 cfg kept", rd_data, 32'h300);
    rd_addr = 8'h04; tick();
    chk("R10 halt read", rd_data, 1);
    wr(8'h04, 32'h100);
    chk("R2 halt release", {31'd0, halt_req}, 0);
    rd_addr = 8'h08;
    sm_active = 0; tick();

    for (int i = 0; i < 600; i++) begin
      sm_active      = ($urandom % 3) == 0;
      mem_wr_pend    = ($urandom % 3) == 0;
      cmd_fifo_empty = ($urandom % 2) == 0;
      rd_addr        = (i % 3 == 0) ? 8'h04 : ((i % 3 == 1) ? 8'h08 : 8'h0C);
      if ($urandom % 5 == 0) begin
        wr_en = 1;
        wr_addr = ($urandom % 4 == 0) ? 8'h04 : (($urandom % 6 == 0) ? 8'h10 : 8'h08);
        wr_data = (wr_addr == 8'h04) ? (($urandom % 2) ? 32'h0 : ($urandom & 32'hFFF))
                                     : $urandom;
      end else wr_en = 0;
      if (i == 400) rst_n = 0;
      if (i == 402) rst_n = 1;
      tick();
    end
    wr_en = 0;
    rst_n = 0; tick(); rst_n = 1; rd_addr = 8'h08;
    chk("R1 reset again busy", {31'd0, busy}, 0);
    chk("R1 reset again cfg", rd_data, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule